// File: doc/BRIEF.md
# Timer-Scheduled I/O Channel

This block is a single pin-level channel that acts on one pin at a time that software sets ahead. A shared free-running time base is compared against a programmed compare time. When the two match, the channel acts on its pin and asks a downstream vector queue to accept the channel's handler address. The handler then sets up the next event. The channel does not use a periodic timer or a pin-change interrupt: each arming gives exactly one event.

In output mode, software first loads the value the pin should take next, then loads the absolute time at which that value is due. When the time is reached, the value moves onto the pin and a push request is raised. In input mode, the pin is brought through a two-flop synchronizer. When the time is reached, the synchronized level is latched into a sample register. The handler reads that register and programs the time of the next sampling event.

Register map on the 3-bit offset bus:
- 0: control and status. Write bit0 for direction (1 = output) and bit1 to clear the missed flag. Read bit0 for direction, bit1 for the missed flag and bit2 for the armed state.
- 1: handler address.
- 2: next output value, in bit0.
- 3: compare time. A write arms the channel.
- 4: sample register, read in bit0.

Top module: `sio_chan`

## Requirements
- R1: After reset, pin_o, pin_oe_o and push_req_o are 0. Status reads 0 for armed, missed and direction, and the sample (offset 4, bit0) reads 0.
- R2: A write to offset 3 sets the armed bit (status bit2). The event on a match clears it, so one arming yields exactly one push request, even as time keeps running.
- R3: In output mode (control bit0 = 1), pin_o takes the value of offset 2 bit0 on the same clock edge where time_i equals the compare time. push_req_o rises on that same edge.
- R4: In input mode (control bit0 = 0), the event latches the synchronized pin level into the sample register. Pin changes after the event leave the sample unchanged.
- R5: A push request presents the handler address that was current at the event on push_vec_o. It holds both until push_ack_i is seen high at a clock edge, and drops on that edge.
- R6: An event that occurs while a request is still unaccepted sets the missed flag (status bit1). The flag stays set until control bit1 is written as 1.
- R7: While the channel is not armed, pin_o keeps its last driven value and no push request is made, even if the next-value register is rewritten.
- R8: An event requires exact equality. A compare time already in the past produces no event while the time base moves on.
- R9: pin_oe_o follows control bit0. In input mode, an event leaves pin_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | TIME_W | Register write data |
| reg_rdata_o | output | TIME_W | Register read data (combinational) |
| time_i | input | TIME_W | Shared free-running time base |
| pin_i | input | 1 | Pin level in input mode (asynchronous) |
| pin_o | output | 1 | Driven pin level |
| pin_oe_o | output | 1 | Pin output enable |
| push_req_o | output | 1 | Request to enqueue the handler |
| push_vec_o | output | HND_W | Handler address to enqueue |
| push_ack_i | input | 1 | Queue accepted the request |

## Verification
The assertions assume that time_i is stable across each clock edge. They also assume that push_ack_i is treated by the queue as meaningful only while a request is pending. The stimulus moves the time base and all other inputs only on the falling edge, and raises the acknowledge only after it has seen a request. The assertions also assume that a compare write and an event rarely meet in one cycle. The bench always arms with several cycles of lead time, so the two never coincide.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] OFS_HND  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_NXT  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CMP  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_SMP  = 3'd4;

  typedef enum logic {DIR_IN = 1'b0, DIR_OUT = 1'b1} dir_e;

  typedef struct packed {
    logic armed;
    logic missed;
    logic dir;
  } stat_t;
endpackage

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned HND_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [TIME_W-1:0] wdata_i,
  input  stat_t             stat_i,
  input  logic              sample_i,
  output dir_e              dir_o,
  output logic [HND_W-1:0]  hnd_o,
  output logic              nxt_o,
  output logic [TIME_W-1:0] cmp_o,
  output logic              cmp_we_o,
  output logic              clr_missed_o,
  output logic [TIME_W-1:0] rdata_o
);
  localparam int unsigned STAT_W = $bits(stat_t);

  dir_e              dir_q;
  logic [HND_W-1:0]  hnd_q;
  logic              nxt_q;
  logic [TIME_W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_IN;
      hnd_q <= '0;
      nxt_q <= 1'b0;
      cmp_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_CTRL: dir_q <= dir_e'(wdata_i[0]);
        OFS_HND:  hnd_q <= wdata_i[HND_W-1:0];
        OFS_NXT:  nxt_q <= wdata_i[0];
        OFS_CMP:  cmp_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cmp_we_o     = we_i && (addr_i == OFS_CMP);
  assign clr_missed_o = we_i && (addr_i == OFS_CTRL) && wdata_i[1];
  assign dir_o        = dir_q;
  assign hnd_o        = hnd_q;
  assign nxt_o        = nxt_q;
  assign cmp_o        = cmp_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: rdata_o[STAT_W-1:0] = stat_i;
      OFS_HND:  rdata_o[HND_W-1:0]  = hnd_q;
      OFS_NXT:  rdata_o[0]          = nxt_q;
      OFS_CMP:  rdata_o             = cmp_q;
      OFS_SMP:  rdata_o[0]          = sample_i;
      default:  rdata_o             = '0;
    endcase
  end
endmodule

// File: rtl/sio_sched.sv
module sio_sched #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] cmp_i,
  input  logic              cmp_we_i,
  output logic              fire_o,
  output logic              armed_o
);
  logic armed_q;

  assign fire_o  = armed_q && (time_i == cmp_i);
  assign armed_o = armed_q;

  // a fresh compare write wins over a same-cycle expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (cmp_we_i) armed_q <= 1'b1;
    else if (fire_o)   armed_q <= 1'b0;
  end

  p_single_shot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !cmp_we_i) |=> !armed_o);
  p_arm_on_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> armed_o);
endmodule

// File: rtl/sio_pin.sv
module sio_pin
  import sio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fire_i,
  input  dir_e dir_i,
  input  logic nxt_i,
  output logic pin_o,
  output logic sample_o
);
  logic [1:0] sync_q;
  logic       pin_q;
  logic       smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      pin_q  <= 1'b0;
      smp_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (fire_i) begin
        if (dir_i == DIR_OUT) pin_q <= nxt_i;
        else                  smp_q <= sync_q[1];
      end
    end
  end

  assign pin_o    = pin_q;
  assign sample_o = smp_q;

  p_out_update_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && dir_i == DIR_OUT) |=> pin_o == $past(nxt_i));
  p_pin_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(pin_o));
  p_in_no_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == DIR_IN) |=> $stable(pin_o));
  p_sample_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(sample_o));
endmodule

// File: rtl/sio_push.sv
module sio_push #(
  parameter int unsigned HND_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [HND_W-1:0] hnd_i,
  input  logic             ack_i,
  input  logic             clr_missed_i,
  output logic             req_o,
  output logic [HND_W-1:0] vec_o,
  output logic             missed_o
);
  logic             req_q;
  logic [HND_W-1:0] vec_q;
  logic             miss_q;
  logic             overrun;

  assign overrun = fire_i && req_q && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (fire_i) begin
      req_q <= 1'b1;
      vec_q <= hnd_i;
    end else if (req_q && ack_i) begin
      req_q <= 1'b0;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           miss_q <= 1'b0;
    else if (overrun)      miss_q <= 1'b1;
    else if (clr_missed_i) miss_q <= 1'b0;
  end

  assign req_o    = req_q;
  assign vec_o    = vec_q;
  assign missed_o = miss_q;

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !fire_i) |=> req_o && $stable(vec_o));
  p_req_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && !fire_i) |=> !req_o);
  p_missed_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (missed_o && !clr_missed_i) |=> missed_o);
  p_no_req_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !fire_i) |=> !req_o);
endmodule

// File: rtl/sio_chan.sv
module sio_chan
  import sio_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned HND_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [TIME_W-1:0] reg_wdata_i,
  output logic [TIME_W-1:0] reg_rdata_o,
  input  logic [TIME_W-1:0] time_i,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              push_req_o,
  output logic [HND_W-1:0]  push_vec_o,
  input  logic              push_ack_i
);
  dir_e              dir;
  logic [HND_W-1:0]  hnd;
  logic              nxt;
  logic [TIME_W-1:0] cmp;
  logic              cmp_we;
  logic              clr_missed;
  logic              fire;
  logic              armed;
  logic              missed;
  logic              sample;
  stat_t             stat;

  assign stat = '{armed: armed, missed: missed, dir: dir};

  sio_regs #(.TIME_W(TIME_W), .HND_W(HND_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .stat_i(stat), .sample_i(sample),
    .dir_o(dir), .hnd_o(hnd), .nxt_o(nxt), .cmp_o(cmp),
    .cmp_we_o(cmp_we), .clr_missed_o(clr_missed), .rdata_o(reg_rdata_o)
  );

  sio_sched #(.TIME_W(TIME_W)) u_sched (
    .clk_i, .rst_ni, .time_i, .cmp_i(cmp), .cmp_we_i(cmp_we),
    .fire_o(fire), .armed_o(armed)
  );

  sio_pin u_pin (
    .clk_i, .rst_ni, .pin_i, .fire_i(fire), .dir_i(dir), .nxt_i(nxt),
    .pin_o, .sample_o(sample)
  );

  sio_push #(.HND_W(HND_W)) u_push (
    .clk_i, .rst_ni, .fire_i(fire), .hnd_i(hnd), .ack_i(push_ack_i),
    .clr_missed_i(clr_missed), .req_o(push_req_o), .vec_o(push_vec_o),
    .missed_o(missed)
  );

  assign pin_oe_o = (dir == DIR_OUT);

  p_oe_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_CTRL) |=> pin_oe_o == $past(reg_wdata_i[0]));
  p_req_on_fire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> push_req_o);
endmodule

// File: tb/sio_chan_bench.sv
`timescale 1ns/1ps
module sio_chan_bench;
  localparam int unsigned TIME_W = 32;
  localparam int unsigned HND_W  = 16;
  localparam int NVEC = 6;
  // {dir, next, pin, handler[7:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 8'h11},
    {1'b1, 1'b0, 1'b1, 8'h22},
    {1'b0, 1'b1, 1'b1, 8'h33},
    {1'b0, 1'b0, 1'b0, 8'h44},
    {1'b1, 1'b1, 1'b1, 8'h55},
    {1'b0, 1'b1, 1'b0, 8'h66}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [2:0]        addr = '0;
  logic [TIME_W-1:0] wdata = '0;
  logic [TIME_W-1:0] rdata;
  logic [TIME_W-1:0] tb_time = 32'd100;
  logic              pin_in = 1'b0;
  logic              pin_out, pin_oe, req, ack = 1'b0;
  logic [HND_W-1:0]  vec;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tb_time <= tb_time + 1;

  sio_chan #(.TIME_W(TIME_W), .HND_W(HND_W)) u_sio_chan (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .time_i(tb_time),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .push_req_o(req), .push_vec_o(vec), .push_ack_i(ack)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [TIME_W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [TIME_W-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1;
  endtask

  logic [TIME_W-1:0] r;
  logic exp_pin, exp_smp;

  initial begin
    #200_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(pin_out == 1'b0, "R1 pin_o", pin_out, 0);
    chk(pin_oe == 1'b0, "R1 pin_oe_o", pin_oe, 0);
    chk(req == 1'b0, "R1 push_req_o", req, 0);
    rd(3'd0, r); chk(r[2:0] == 3'b000, "R1 status", r[2:0], 0);
    rd(3'd4, r); chk(r[0] == 1'b0, "R1 sample", r[0], 0);

    exp_pin = 1'b0; exp_smp = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      logic [TIME_W-1:0] cmpv;
      wr(3'd0, {31'd0, VEC[i][10]});
      wr(3'd1, {24'd0, VEC[i][7:0]});
      wr(3'd2, {31'd0, VEC[i][9]});
      pin_in = VEC[i][8];
      wait_cyc(3);
      chk(pin_oe == VEC[i][10], "R9 pin_oe_o", pin_oe, VEC[i][10]);
      cmpv = tb_time + 8;
      wr(3'd3, cmpv);
      #1;
      chk(req == 1'b0 && pin_out == exp_pin, "R7 before event", {req, pin_out}, {1'b0, exp_pin});
      rd(3'd0, r); chk(r[2] == 1'b1, "R2 armed", r[2], 1);
      wait_cyc(12);
      if (VEC[i][10]) exp_pin = VEC[i][9]; else exp_smp = VEC[i][8];
      chk(req == 1'b1, "R3 push_req_o", req, 1);
      chk(vec == {8'd0, VEC[i][7:0]}, "R5 push_vec_o", vec, VEC[i][7:0]);
      chk(pin_out == exp_pin, VEC[i][10] ? "R3 pin_o" : "R9 pin_o", pin_out, exp_pin);
      rd(3'd4, r); chk(r[0] == exp_smp, "R4 sample", r[0], exp_smp);
      rd(3'd0, r); chk(r[2] == 1'b0, "R2 disarmed", r[2], 0);
      pin_in = ~pin_in;
      wait_cyc(4);
      chk(req == 1'b1, "R5 request held", req, 1);
      do_ack();
      chk(req == 1'b0, "R5 drop on ack", req, 0);
      rd(3'd4, r); chk(r[0] == exp_smp, "R4 sample stable", r[0], exp_smp);
    end

    // R2 / R7: no second event, pin held when next value changes unarmed
    wr(3'd0, 32'd1);
    wr(3'd2, {31'd0, ~exp_pin});
    wait_cyc(20);
    chk(req == 1'b0, "R2 single event", req, 0);
    chk(pin_out == exp_pin, "R7 pin held", pin_out, exp_pin);

    // R8: compare time in the past never matches
    wr(3'd3, tb_time - 3);
    wait_cyc(20);
    chk(req == 1'b0, "R8 past compare", req, 0);
    chk(pin_out == exp_pin, "R8 pin unchanged", pin_out, exp_pin);

    // R6: overrun sets sticky missed flag
    wr(3'd0, 32'd0);
    wr(3'd1, 32'h0077);
    wr(3'd3, tb_time + 6);
    wait_cyc(12);
    chk(req == 1'b1, "R6 first request", req, 1);
    wr(3'd1, 32'h0088);
    wr(3'd3, tb_time + 6);
    wait_cyc(12);
    rd(3'd0, r); chk(r[1] == 1'b1, "R6 missed set", r[1], 1);
    chk(vec == 16'h0088, "R5 latest handler", vec, 16'h0088);
    do_ack();
    wait_cyc(5);
    rd(3'd0, r); chk(r[1] == 1'b1, "R6 missed sticky", r[1], 1);
    wr(3'd0, 32'd2);
    rd(3'd0, r); chk(r[1] == 1'b0, "R6 missed cleared", r[1], 0);
    chk(pin_oe == 1'b0, "R9 oe after clear write", pin_oe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule